// File: doc/BRIEF.md
# Single-Cycle Integer Execute Unit

This block executes one 32-bit fixed-length instruction per clock cycle from a small integer subset. It decodes three layouts: register-to-register, register-with-16-bit-constant and long-target. It reads up to two source registers from an internal file of 32 words of 32 bits and computes a result. The result is written back on the next rising clock edge. Loads and stores are served through a word-wide data memory port. That port carries a byte address, and the memory is expected to use only the upper 30 bits of it.

Instruction fetch and sequencing belong to a separate sequencer. The instruction word arrives on a plain input, and the unit gives the sequencer an equality flag that compares its two source registers. Loads expect a memory read port with no latency, because the returned word is written back in the same cycle as the access.

Top module: `risc_exec_core`

## Requirements
- R1: After reset is released, every register reads as zero.
- R2: Register 0 always reads as zero, and any instruction that targets it leaves it at zero.
- R3: With opcode 0, funct 32 (add), 34 (subtract), 36 (bitwise and) and 37 (bitwise or) combine the registers named in bits [25:21] and [20:16]. The result is written to the register named in bits [15:11] at the next rising edge.
- R4: slt (opcode 0, funct 42) and slti (opcode 10) write 1 when the first operand is less than the second as signed two's-complement values, and 0 otherwise.
- R5: sll (opcode 0, funct 0) and srl (opcode 0, funct 6) shift the bits [20:16] register by the amount in bits [10:6], fill with zeros, and write to the bits [15:11] register.
- R6: addi (opcode 8) and slti sign-extend the 16-bit constant in bits [15:0]. andi (opcode 12) and ori (opcode 13) zero-extend it. The result goes to the bits [20:16] register.
- R7: lui (opcode 15) writes the constant into bits [31:16] of the bits [20:16] register and clears its lower half.
- R8: A load (opcode 35) drives the memory address with the bits [25:21] register plus the sign-extended constant, holds the write enable low, and writes the returned word into the bits [20:16] register at the next edge.
- R9: A store (opcode 43) drives the same address form, drives the write data with the bits [20:16] register, and raises the write enable in the same cycle.
- R10: An opcode outside the set above, or an opcode-0 funct outside the set above, writes neither a register nor memory.
- R11: The equality flag is high exactly when the two source registers selected by bits [25:21] and [20:16] hold equal values, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word executed this cycle |
| dmem_addr_o | output | 32 | Byte address for a load or store |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store enable |
| dmem_rdata_i | input | 32 | Word returned by memory in the same cycle |
| eq_flag_o | output | 1 | The two source registers are equal |

## Verification
The properties assume that the instruction word and the memory read data are stable and known across each sampling edge. They also assume that memory answers a load within the same cycle. The stimulus changes its inputs shortly after a rising edge and holds them for the rest of the cycle. It drives a known read word alongside every load. The bench sees register contents only through the store path: it issues a store with base register 0 and reads the selected register on the write-data port.

// File: rtl/rx_pkg.sv
package rx_pkg;

   localparam logic [5:0] OPC_REG   = 6'd0;
   localparam logic [5:0] OPC_ADDI  = 6'd8;
   localparam logic [5:0] OPC_SLTI  = 6'd10;
   localparam logic [5:0] OPC_ANDI  = 6'd12;
   localparam logic [5:0] OPC_ORI   = 6'd13;
   localparam logic [5:0] OPC_LUI   = 6'd15;
   localparam logic [5:0] OPC_LOAD  = 6'd35;
   localparam logic [5:0] OPC_STORE = 6'd43;

   localparam logic [5:0] FN_SLL = 6'd0;
   localparam logic [5:0] FN_SRL = 6'd6;
   localparam logic [5:0] FN_ADD = 6'd32;
   localparam logic [5:0] FN_SUB = 6'd34;
   localparam logic [5:0] FN_AND = 6'd36;
   localparam logic [5:0] FN_OR  = 6'd37;
   localparam logic [5:0] FN_SLT = 6'd42;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL, ALU_SRL, ALU_HI
   } alu_fn_e;

   typedef struct packed {
      alu_fn_e fn;
      logic    use_imm;
      logic    imm_signed;
      logic    dest_is_rt;
      logic    reg_wr;
      logic    mem_rd;
      logic    mem_wr;
   } ctrl_t;

endpackage

// File: rtl/rx_decode.sv
module rx_decode
   import rx_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '{fn: ALU_ADD, use_imm: 1'b1, imm_signed: 1'b1, dest_is_rt: 1'b1,
               reg_wr: 1'b0, mem_rd: 1'b0, mem_wr: 1'b0};
      unique case (opcode)
         OPC_REG: begin
            ctrl.use_imm    = 1'b0;
            ctrl.dest_is_rt = 1'b0;
            ctrl.reg_wr     = 1'b1;
            case (funct)
               FN_ADD:  ctrl.fn = ALU_ADD;
               FN_SUB:  ctrl.fn = ALU_SUB;
               FN_AND:  ctrl.fn = ALU_AND;
               FN_OR:   ctrl.fn = ALU_OR;
               FN_SLT:  ctrl.fn = ALU_SLT;
               FN_SLL:  ctrl.fn = ALU_SLL;
               FN_SRL:  ctrl.fn = ALU_SRL;
               default: ctrl.reg_wr = 1'b0;
            endcase
         end
         OPC_ADDI:  ctrl.reg_wr = 1'b1;
         OPC_SLTI: begin
            ctrl.fn     = ALU_SLT;
            ctrl.reg_wr = 1'b1;
         end
         OPC_ANDI: begin
            ctrl.fn         = ALU_AND;
            ctrl.imm_signed = 1'b0;
            ctrl.reg_wr     = 1'b1;
         end
         OPC_ORI: begin
            ctrl.fn         = ALU_OR;
            ctrl.imm_signed = 1'b0;
            ctrl.reg_wr     = 1'b1;
         end
         OPC_LUI: begin
            ctrl.fn         = ALU_HI;
            ctrl.imm_signed = 1'b0;
            ctrl.reg_wr     = 1'b1;
         end
         OPC_LOAD: begin
            ctrl.reg_wr = 1'b1;
            ctrl.mem_rd = 1'b1;
         end
         OPC_STORE: ctrl.mem_wr = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/rx_regfile.sv
module rx_regfile #(
   parameter int  XLEN       = 32,
   parameter int  NREG       = 32,
   parameter bit  RESET_REGS = 1'b1,
   localparam int IDX_W      = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [XLEN-1:0]  ra_data,
   output logic [XLEN-1:0]  rb_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [XLEN-1:0]  wr_data
);
   logic [XLEN-1:0] cells [NREG];
   logic            wr_live;

   assign wr_live = wr_en && (wr_idx != '0);

   if (RESET_REGS) begin : g_rst_store
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NREG; i++) cells[i] <= '0;
         end else if (wr_live) begin
            cells[wr_idx] <= wr_data;
         end
      end
   end else begin : g_plain_store
      always_ff @(posedge clk) begin
         if (wr_live) cells[wr_idx] <= wr_data;
      end
   end

   assign ra_data = (ra_idx == '0) ? '0 : cells[ra_idx];
   assign rb_data = (rb_idx == '0) ? '0 : cells[rb_idx];
endmodule

// File: rtl/rx_alu.sv
module rx_alu
   import rx_pkg::*;
#(
   parameter int  XLEN   = 32,
   parameter int  SH_W   = 5,
   localparam int HALF_W = XLEN / 2
) (
   input  alu_fn_e         fn,
   input  logic [XLEN-1:0] opa,
   input  logic [XLEN-1:0] opb,
   input  logic [SH_W-1:0] shamt,
   output logic [XLEN-1:0] res
);
   always_comb begin
      unique case (fn)
         ALU_ADD: res = opa + opb;
         ALU_SUB: res = opa - opb;
         ALU_AND: res = opa & opb;
         ALU_OR:  res = opa | opb;
         ALU_SLT: res = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
         ALU_SLL: res = opb << shamt;
         ALU_SRL: res = opb >> shamt;
         ALU_HI:  res = {opb[HALF_W-1:0], {HALF_W{1'b0}}};
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/risc_exec_core.sv
module risc_exec_core
   import rx_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter bit RESET_REGS = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] instr_i,
   output logic [31:0] dmem_addr_o,
   output logic [31:0] dmem_wdata_o,
   output logic        dmem_we_o,
   input  logic [31:0] dmem_rdata_i,
   output logic        eq_flag_o
);
   localparam int IDX_W = $clog2(NREG);
   localparam int IMM_W = 16;
   localparam int SH_W  = 5;

   if (XLEN != 32) begin : g_bad_xlen
      $error("risc_exec_core: XLEN must be 32 for the fixed instruction layout");
   end
   if (NREG != 32) begin : g_bad_nreg
      $error("risc_exec_core: NREG must be 32 to match 5-bit register fields");
   end

   logic [5:0]       f_op, f_fn;
   logic [IDX_W-1:0] f_rs, f_rt, f_rd;
   logic [SH_W-1:0]  f_sh;
   logic [IMM_W-1:0] f_imm;

   assign f_op  = instr_i[31:26];
   assign f_rs  = instr_i[25:21];
   assign f_rt  = instr_i[20:16];
   assign f_rd  = instr_i[15:11];
   assign f_sh  = instr_i[10:6];
   assign f_fn  = instr_i[5:0];
   assign f_imm = instr_i[15:0];

   ctrl_t           ctl;
   logic [XLEN-1:0] rs_val, rt_val, imm_ext, opb, alu_y;
   logic            wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [XLEN-1:0] wr_data;

   rx_decode u_dec (.opcode(f_op), .funct(f_fn), .ctrl(ctl));

   rx_regfile #(.XLEN(XLEN), .NREG(NREG), .RESET_REGS(RESET_REGS)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra_idx(f_rs), .rb_idx(f_rt),
      .ra_data(rs_val), .rb_data(rt_val),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   assign imm_ext = ctl.imm_signed ? {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm}
                                   : {{(XLEN-IMM_W){1'b0}}, f_imm};
   assign opb     = ctl.use_imm ? imm_ext : rt_val;

   rx_alu #(.XLEN(XLEN), .SH_W(SH_W)) u_alu (
      .fn(ctl.fn), .opa(rs_val), .opb(opb), .shamt(f_sh), .res(alu_y)
   );

   assign wr_en   = ctl.reg_wr;
   assign wr_idx  = ctl.dest_is_rt ? f_rt : f_rd;
   assign wr_data = ctl.mem_rd ? dmem_rdata_i : alu_y;

   assign dmem_addr_o  = alu_y;
   assign dmem_wdata_o = rt_val;
   assign dmem_we_o    = ctl.mem_wr;
   assign eq_flag_o    = (rs_val == rt_val);
endmodule

// File: rtl/risc_exec_core_chk.sv
module risc_exec_core_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] instr_i,
   input logic [31:0] dmem_addr_o,
   input logic [31:0] dmem_wdata_o,
   input logic        dmem_we_o,
   input logic        eq_flag_o,
   input logic [31:0] rs_val,
   input logic [31:0] rt_val,
   input logic        wr_en,
   input logic [4:0]  wr_idx,
   input logic [31:0] wr_data
);
   function automatic bit known_op(input logic [31:0] w);
      logic [5:0] o, f;
      o = w[31:26];
      f = w[5:0];
      if (o == 6'd0)
         return f inside {6'd0, 6'd6, 6'd32, 6'd34, 6'd36, 6'd37, 6'd42};
      return o inside {6'd8, 6'd10, 6'd12, 6'd13, 6'd15, 6'd35, 6'd43};
   endfunction

   // R2: selecting register 0 as a source yields zero
   a_r2_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[25:21] == 5'd0) |-> (rs_val == 32'd0));

   // R11: same source field implies the equality flag
   a_r11_same_field_eq: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[25:21] == instr_i[20:16]) |-> eq_flag_o);

   // R8: load address and no store
   a_r8_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[31:26] == 6'd35) |->
         (!dmem_we_o && dmem_addr_o == rs_val + {{16{instr_i[15]}}, instr_i[15:0]}));

   // R9: store drives enable and the source register value
   a_r9_store_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[31:26] == 6'd43) |-> (dmem_we_o && dmem_wdata_o == rt_val && !wr_en));

   // R7: upper-immediate write value
   a_r7_upper_imm: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_i[31:26] == 6'd15) |->
         (wr_en && wr_idx == instr_i[20:16] && wr_data == {instr_i[15:0], 16'h0000}));

   // R10: unknown encodings write nothing
   a_r10_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
      !known_op(instr_i) |-> (!wr_en && !dmem_we_o));
endmodule

bind risc_exec_core risc_exec_core_chk chk_i (
   .clk(clk), .rst_n(rst_n), .instr_i(instr_i),
   .dmem_addr_o(dmem_addr_o), .dmem_wdata_o(dmem_wdata_o),
   .dmem_we_o(dmem_we_o), .eq_flag_o(eq_flag_o),
   .rs_val(rs_val), .rt_val(rt_val),
   .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/risc_exec_core_tb_top.sv
module risc_exec_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = 32'd0;
   logic [31:0] rdata = 32'd0;
   logic [31:0] addr, wdata;
   logic        we, eqf;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   risc_exec_core dut_i (
      .clk(clk), .rst_n(rst_n), .instr_i(instr),
      .dmem_addr_o(addr), .dmem_wdata_o(wdata), .dmem_we_o(we),
      .dmem_rdata_i(rdata), .eq_flag_o(eqf)
   );

   typedef struct {
      string       tag;
      bit          cw; logic [31:0] ew;
      bit          ca; logic [31:0] ea;
      bit          ce; logic        ee;
      bit          cf; logic        ef;
   } exp_t;

   exp_t sb_q[$];

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
   endfunction

   function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
      return {op[5:0], rs[4:0], rt[4:0], imm};
   endfunction

   task automatic issue(input logic [31:0] ins, input logic [31:0] rd_word,
                        input bit chk, input exp_t e);
      @(posedge clk);
      #2;
      instr = ins;
      rdata = rd_word;
      if (chk) sb_q.push_back(e);
   endtask

   task automatic exec(input logic [31:0] ins);
      exp_t e;
      e = '{tag: "", cw: 0, ew: 0, ca: 0, ea: 0, ce: 0, ee: 0, cf: 0, ef: 0};
      issue(ins, 32'd0, 1'b0, e);
   endtask

   // store with base register 0 exposes register idx on the write-data port
   task automatic peek(input int idx, input logic [31:0] expv, input string tag);
      exp_t e;
      e = '{tag: tag, cw: 1, ew: expv, ca: 1, ea: 32'd0, ce: 1, ee: 1'b1, cf: 0, ef: 0};
      issue(enc_i(43, 0, idx, 16'h0000), 32'd0, 1'b1, e);
   endtask

   task automatic memchk(input logic [31:0] ins, input logic [31:0] rd_word,
                         input logic [31:0] ea, input logic ee, input bit cw,
                         input logic [31:0] ew, input string tag);
      exp_t e;
      e = '{tag: tag, cw: cw, ew: ew, ca: 1, ea: ea, ce: 1, ee: ee, cf: 0, ef: 0};
      issue(ins, rd_word, 1'b1, e);
   endtask

   task automatic flagchk(input logic [31:0] ins, input logic ef, input string tag);
      exp_t e;
      e = '{tag: tag, cw: 0, ew: 0, ca: 0, ea: 0, ce: 1, ee: 1'b0, cf: 1, ef: ef};
      issue(ins, 32'd0, 1'b1, e);
   endtask

   task automatic cmp(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
      end
   endtask

   // monitor: pops the item pushed this cycle and compares late in the cycle
   initial begin
      forever begin
         @(posedge clk);
         #15;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.cw) cmp(e.tag, "wdata", wdata, e.ew);
            if (e.ca) cmp(e.tag, "addr", addr, e.ea);
            if (e.ce) cmp(e.tag, "we", {31'd0, we}, {31'd0, e.ee});
            if (e.cf) cmp(e.tag, "eq", {31'd0, eqf}, {31'd0, e.ef});
         end
      end
   end

   initial begin
      #(20 * 20000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1: registers clear after reset
      peek(7, 32'h0, "R1 r7");
      peek(31, 32'h0, "R1 r31");

      // R7 and R6: build a full word from halves
      exec(enc_i(15, 0, 1, 16'hDF5A));
      peek(1, 32'hDF5A0000, "R7 lui");
      exec(enc_i(13, 1, 1, 16'h48F5));
      peek(1, 32'hDF5A48F5, "R6 ori");

      // R6: sign extension vs zero extension
      exec(enc_i(8, 0, 2, 16'hFFFF));
      peek(2, 32'hFFFFFFFF, "R6 addi sext");
      exec(enc_i(13, 0, 3, 16'hFFFF));
      peek(3, 32'h0000FFFF, "R6 ori zext");
      exec(enc_i(12, 2, 4, 16'h8001));
      peek(4, 32'h00008001, "R6 andi zext");

      // R3: register-format arithmetic and logic
      exec(enc_r(1, 3, 5, 0, 32));
      peek(5, 32'hDF5B48F4, "R3 add");
      exec(enc_r(3, 2, 6, 0, 34));
      peek(6, 32'h00010000, "R3 sub");
      exec(enc_r(1, 3, 7, 0, 36));
      peek(7, 32'h000048F5, "R3 and");
      exec(enc_r(1, 3, 8, 0, 37));
      peek(8, 32'hDF5AFFFF, "R3 or");

      // R4: signed compares
      exec(enc_r(2, 3, 9, 0, 42));
      peek(9, 32'd1, "R4 slt neg<pos");
      exec(enc_r(3, 2, 10, 0, 42));
      peek(10, 32'd0, "R4 slt pos<neg");
      exec(enc_i(10, 2, 11, 16'h0000));
      peek(11, 32'd1, "R4 slti -1<0");
      exec(enc_i(10, 3, 12, 16'hFFFF));
      peek(12, 32'd0, "R4 slti sext");

      // R5: shifts by the dedicated amount field
      exec(enc_r(0, 1, 13, 8, 0));
      peek(13, 32'h5A48F500, "R5 sll");
      exec(enc_r(0, 1, 14, 4, 6));
      peek(14, 32'h0DF5A48F, "R5 srl");

      // R2: writes to register 0 are dropped
      exec(enc_i(8, 2, 0, 16'h0005));
      peek(0, 32'h0, "R2 addi to r0");
      exec(enc_r(1, 3, 0, 0, 37));
      peek(0, 32'h0, "R2 or to r0");
      exec(enc_r(0, 3, 15, 0, 32));
      peek(15, 32'h0000FFFF, "R2 r0 as source");

      // R8: load address, no store, returned word lands in rt
      memchk(enc_i(35, 3, 16, 16'h0008), 32'h12345678, 32'h00010007, 1'b0,
             1'b0, 32'h0, "R8 load");
      peek(16, 32'h12345678, "R8 load writeback");

      // R9: store with negative offset
      memchk(enc_i(43, 3, 1, 16'hFFFC), 32'h0, 32'h0000FFFB, 1'b1,
             1'b1, 32'hDF5A48F5, "R9 store");

      // R10: undefined opcode and funct
      memchk(enc_i(63, 1, 17, 16'h0001), 32'h0, 32'hDF5A48F6, 1'b0,
             1'b0, 32'h0, "R10 undefined op no store");
      peek(17, 32'h0, "R10 undefined op no write");
      exec(enc_r(1, 3, 18, 0, 1));
      peek(18, 32'h0, "R10 undefined funct");

      // R11: equality flag on register contents
      flagchk(enc_i(4, 1, 1, 16'h0), 1'b1, "R11 same reg");
      flagchk(enc_i(4, 1, 3, 16'h0), 1'b0, "R11 differ");
      flagchk(enc_i(4, 3, 15, 16'h0), 1'b1, "R11 equal values");

      repeat (3) @(posedge clk);
      #5;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule